// File: doc/BRIEF.md
# Slice-Based Bitmap Overlay Generator

This block draws a two-bit-per-pixel bitmap overlay on top of a video picture. The bitmap lives in a store of 48 narrow columns called slices. Each slice is 8 pixels wide and 32 lines tall. A separate list of 44 slice codes decides which slice appears in each 8-pixel column of the 352-pixel-wide window. To move or reorder what is shown, the host rewrites that list and leaves the bitmap untouched.

During display, the video timing logic presents a window coordinate every clock. One clock later the block returns either a colour from a three-entry palette or a transparent flag. A downstream mixer uses that result to replace the video pixel or let it through. A double-height option shows each stored line twice, so an object can be up to 64 lines tall.

The host loads everything through one write port with a valid/ready handshake. `wr_ready` is always high, so the port never applies back-pressure and a beat is taken on every cycle in which `wr_valid` is high. The pixel path is locked to video timing and has no ready: a result is produced for every presented coordinate.

Top module: `osd_overlay`

## Requirements
- R1: Results are registered. `out_valid` equals `pix_valid` of the previous cycle, and a cycle with `pix_valid` low produces `out_transp`=1 and `out_color`=0 one clock later.
- R2: The bitmap word for slice s, line l is at `wr_addr` = s*32+l (`wr_sel`=0, data bits [15:0]). Pixel p of the slice, with 0 as the leftmost, is held in data bits [2p+1:2p].
- R3: Window column c = `pix_x`/8 shows the slice whose code is in sequence entry c (`wr_sel`=1, `wr_addr`=c from 0 to 43, data bits [5:0]). A code from 48 to 63 is a blank marker and shows as transparent.
- R4: Pixel code 0 is transparent. Codes 1 to 3 select the palette entry written with `wr_sel`=2 and `wr_addr` 1 to 3, with data {Y[23:16],Cb[15:8],Cr[7:0]}. A palette write to address 0 has no effect. Whenever `out_transp` is 1, `out_color` is 0.
- R5: With `dbl_height`=0, lines 0 to 31 are shown and `pix_y` of 32 or more is transparent. With `dbl_height`=1, `pix_y` from 0 to 63 shows stored line `pix_y`/2.
- R6: `pix_x` of 352 or more is transparent.
- R7: Sequence writes go to a shadow copy. The displayed copy takes the shadow's value on a cycle with `frame_start` high and affects pixels presented after that cycle. If a sequence write and `frame_start` fall in the same cycle, the displayed copy takes the shadow value from before that write.
- R8: After reset, `out_valid`=0, `out_transp`=1 and `out_color`=0. Both sequence copies hold the blank code 63 and the palette holds 0.
- R9: `wr_ready` is always 1. `wr_sel`=3 writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Host write beat valid |
| wr_ready | output | 1 | Host write ready (always 1) |
| wr_sel | input | 2 | Write target: 0 bitmap, 1 sequence, 2 palette, 3 none |
| wr_addr | input | 11 | Word address within the target |
| wr_data | input | 24 | Write data |
| frame_start | input | 1 | Copies the shadow sequence into the displayed sequence |
| dbl_height | input | 1 | Double-height display |
| pix_valid | input | 1 | Coordinate valid |
| pix_x | input | 9 | Window pixel column |
| pix_y | input | 6 | Window line |
| out_valid | output | 1 | Result valid |
| out_transp | output | 1 | Pass the underlying video |
| out_color | output | 24 | Overlay colour {Y,Cb,Cr} |

## Verification
Each overlay result is due exactly one rising edge after its coordinate. That holds even though the coordinate is looked up three times on the way: sequence entry, then bitmap word, then palette. The bench drives a coordinate at a falling edge and compares the result at the next falling edge, after the single registering edge. Host writes are taken at the edge that follows the beat, and a new sequence order is taken at the `frame_start` edge. For that reason, reorder checks present pixels both before and after that edge and expect the old order before it and the new order after it.

// File: rtl/osd_pkg.sv
package osd_pkg;
  typedef enum logic [1:0] {
    SEL_BITMAP  = 2'd0,
    SEL_SEQ     = 2'd1,
    SEL_PALETTE = 2'd2,
    SEL_NONE    = 2'd3
  } wr_sel_e;
endpackage

// File: rtl/osd_seq_regs.sv
module osd_seq_regs #(
  parameter int N_COLS = 44,
  parameter int CODE_W = 6,
  localparam int COL_W = $clog2(N_COLS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [COL_W-1:0]  waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic              latch,
  input  logic [COL_W-1:0]  rcol,
  output logic [CODE_W-1:0] rcode
);
  logic [CODE_W-1:0] shadow_q [N_COLS];
  logic [CODE_W-1:0] active_q [N_COLS];

  for (genvar c = 0; c < N_COLS; c++) begin : g_col
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        shadow_q[c] <= '1;
        active_q[c] <= '1;
      end else begin
        if (we && waddr == COL_W'(c)) shadow_q[c] <= wdata;
        if (latch) active_q[c] <= shadow_q[c];
      end
    end
  end

  always_comb begin
    rcode = '1;
    if (32'(rcol) < N_COLS) rcode = active_q[rcol];
  end
endmodule

// File: rtl/osd_bitmap_store.sv
module osd_bitmap_store #(
  parameter int DEPTH  = 1536,
  parameter int WORD_W = 16,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] rdata
);
  logic [WORD_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we && 32'(waddr) < DEPTH) mem_q[waddr] <= wdata;
  end

  always_comb begin
    rdata = '0;
    if (32'(raddr) < DEPTH) rdata = mem_q[raddr];
  end
endmodule

// File: rtl/osd_palette.sv
module osd_palette #(
  parameter int BPP = 2,
  parameter int CW  = 24,
  localparam int N_ENT = (1 << BPP) - 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           we,
  input  logic [BPP-1:0] waddr,
  input  logic [CW-1:0]  wdata,
  input  logic [BPP-1:0] ridx,
  output logic [CW-1:0]  rcolor
);
  logic [CW-1:0] ent_q [N_ENT];

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    always_ff @(posedge clk) begin
      if (!rst_n) ent_q[i] <= '0;
      else if (we && waddr == BPP'(i + 1)) ent_q[i] <= wdata;
    end
  end

  always_comb begin
    rcolor = '0;
    if (ridx != '0) rcolor = ent_q[ridx - 1'b1];
  end
endmodule

// File: rtl/osd_overlay.sv
module osd_overlay #(
  parameter int SLICE_W  = 8,
  parameter int SLICE_H  = 32,
  parameter int N_SLICES = 48,
  parameter int N_COLS   = 44,
  parameter int BPP      = 2,
  parameter int CW       = 24,
  localparam int WIN_W   = N_COLS * SLICE_W,
  localparam int WORD_W  = SLICE_W * BPP,
  localparam int DEPTH   = N_SLICES * SLICE_H,
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int CODE_W  = $clog2(N_SLICES),
  localparam int COL_W   = $clog2(N_COLS),
  localparam int LINE_W  = $clog2(SLICE_H),
  localparam int XW      = $clog2(WIN_W),
  localparam int YW      = LINE_W + 1,
  localparam int PX_W    = $clog2(SLICE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [1:0]        wr_sel,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CW-1:0]     wr_data,
  input  logic              frame_start,
  input  logic              dbl_height,
  input  logic              pix_valid,
  input  logic [XW-1:0]     pix_x,
  input  logic [YW-1:0]     pix_y,
  output logic              out_valid,
  output logic              out_transp,
  output logic [CW-1:0]     out_color
);
  import osd_pkg::*;

  logic              bm_we, seq_we, pal_we;
  logic [COL_W-1:0]  col;
  logic [CODE_W-1:0] code;
  logic [LINE_W-1:0] line;
  logic [ADDR_W-1:0] bm_raddr;
  logic [WORD_W-1:0] word;
  logic [BPP-1:0]    pcode;
  logic [CW-1:0]     pal_color;
  logic              x_ok, y_ok, slice_ok, transp;

  assign wr_ready = 1'b1;
  assign bm_we    = wr_valid && wr_sel == SEL_BITMAP;
  assign seq_we   = wr_valid && wr_sel == SEL_SEQ && 32'(wr_addr) < N_COLS;
  assign pal_we   = wr_valid && wr_sel == SEL_PALETTE && 32'(wr_addr) <= (1 << BPP) - 1;

  osd_seq_regs #(.N_COLS(N_COLS), .CODE_W(CODE_W)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (seq_we),
    .waddr (wr_addr[COL_W-1:0]),
    .wdata (wr_data[CODE_W-1:0]),
    .latch (frame_start),
    .rcol  (col),
    .rcode (code)
  );

  osd_bitmap_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_bitmap (
    .clk   (clk),
    .we    (bm_we),
    .waddr (wr_addr),
    .wdata (wr_data[WORD_W-1:0]),
    .raddr (bm_raddr),
    .rdata (word)
  );

  osd_palette #(.BPP(BPP), .CW(CW)) u_pal (
    .clk    (clk),
    .rst_n  (rst_n),
    .we     (pal_we),
    .waddr  (wr_addr[BPP-1:0]),
    .wdata  (wr_data),
    .ridx   (pcode),
    .rcolor (pal_color)
  );

  // coordinate -> column, line, pixel -> slice code -> word -> colour
  always_comb begin
    x_ok     = 32'(pix_x) < WIN_W;
    y_ok     = dbl_height || 32'(pix_y) < SLICE_H;
    col      = COL_W'(pix_x >> PX_W);
    line     = dbl_height ? pix_y[YW-1:1] : pix_y[LINE_W-1:0];
    slice_ok = 32'(code) < N_SLICES;
    bm_raddr = ADDR_W'(32'(code) * SLICE_H + 32'(line));
    pcode    = word[pix_x[PX_W-1:0]*BPP +: BPP];
    transp   = !x_ok || !y_ok || !slice_ok || pcode == '0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_transp <= 1'b1;
      out_color  <= '0;
    end else begin
      out_valid  <= pix_valid;
      out_transp <= !pix_valid || transp;
      out_color  <= (!pix_valid || transp) ? '0 : pal_color;
    end
  end
endmodule

// File: rtl/osd_overlay_chk.sv
module osd_overlay_chk #(
  parameter int XW = 9,
  parameter int YW = 6,
  parameter int CW = 24,
  parameter int WIN_W = 352,
  parameter int SLICE_H = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wr_ready,
  input logic          dbl_height,
  input logic          pix_valid,
  input logic [XW-1:0] pix_x,
  input logic [YW-1:0] pix_y,
  input logic          out_valid,
  input logic          out_transp,
  input logic [CW-1:0] out_color
);
  assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pix_valid |=> out_valid);
  assert_idle_blank_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_valid |=> (!out_valid && out_transp));
  assert_transp_black_R4: assert property (@(posedge clk) disable iff (!rst_n)
    out_transp |-> out_color == '0);
  assert_y_outside_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && !dbl_height && 32'(pix_y) >= SLICE_H) |=> out_transp);
  assert_x_outside_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pix_valid && 32'(pix_x) >= WIN_W) |=> out_transp);
  assert_ready_high_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

bind osd_overlay osd_overlay_chk #(
  .XW(XW), .YW(YW), .CW(CW), .WIN_W(WIN_W), .SLICE_H(SLICE_H)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_ready   (wr_ready),
  .dbl_height (dbl_height),
  .pix_valid  (pix_valid),
  .pix_x      (pix_x),
  .pix_y      (pix_y),
  .out_valid  (out_valid),
  .out_transp (out_transp),
  .out_color  (out_color)
);

// File: tb/tb_osd_overlay.sv
module tb_osd_overlay;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_valid = 1'b0;
  logic        wr_ready;
  logic [1:0]  wr_sel = '0;
  logic [10:0] wr_addr = '0;
  logic [23:0] wr_data = '0;
  logic        frame_start = 1'b0;
  logic        dbl_height = 1'b0;
  logic        pix_valid = 1'b0;
  logic [8:0]  pix_x = '0;
  logic [5:0]  pix_y = '0;
  logic        out_valid, out_transp;
  logic [23:0] out_color;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int          sh_seq [44];
  int          ac_seq [44];
  logic [23:0] pal [4];

  always #2 clk = ~clk;

  osd_overlay dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data),
    .frame_start(frame_start), .dbl_height(dbl_height),
    .pix_valid(pix_valid), .pix_x(pix_x), .pix_y(pix_y),
    .out_valid(out_valid), .out_transp(out_transp), .out_color(out_color)
  );

  function automatic logic [15:0] bm_word(int s, int l);
    return 16'((s * 37 + l * 11 + 5) * 40503);
  endfunction

  function automatic logic [25:0] model(int x, int y, bit d);
    int l, code, pc;
    if (x >= 352) return {1'b1, 1'b1, 24'h0};
    if (!d && y >= 32) return {1'b1, 1'b1, 24'h0};
    l = d ? y / 2 : y;
    code = ac_seq[x / 8];
    if (code >= 48) return {1'b1, 1'b1, 24'h0};
    pc = (bm_word(code, l) >> (2 * (x % 8))) & 3;
    if (pc == 0) return {1'b1, 1'b1, 24'h0};
    return {1'b1, 1'b0, pal[pc]};
  endfunction

  task automatic check(string req, logic [25:0] got, logic [25:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic wr(int sel, int addr, int data);
    @(negedge clk);
    wr_valid = 1'b1; wr_sel = 2'(sel); wr_addr = 11'(addr); wr_data = 24'(data);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic frame();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
    for (int c = 0; c < 44; c++) ac_seq[c] = sh_seq[c];
  endtask

  task automatic px(int x, int y, bit d, string req);
    @(negedge clk);
    pix_valid = 1'b1; pix_x = 9'(x); pix_y = 6'(y); dbl_height = d;
    @(negedge clk);
    pix_valid = 1'b0;
    check(req, {out_valid, out_transp, out_color}, model(x, y, d));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 44; c++) begin sh_seq[c] = 63; ac_seq[c] = 63; end
    for (int i = 0; i < 4; i++) pal[i] = '0;
    repeat (4) @(negedge clk);
    // R8: reset state seen at the ports
    check("R8 reset outputs", {out_valid, out_transp, out_color}, {1'b0, 1'b1, 24'h0});
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 wr_ready R9", {25'h0, wr_ready}, 26'h1);
    // bitmap loaded, sequence still blank: everything transparent (R8, R3)
    for (int s = 0; s < 48; s++)
      for (int l = 0; l < 32; l++) wr(0, s * 32 + l, int'(bm_word(s, l)));
    px(100, 5, 0, "R8 blank sequence after reset");
    px(0, 0, 0, "R8 blank sequence after reset");
    // R4: palette write to address 0 ignored; R9: sel 3 writes nothing
    wr(2, 0, 24'hABCDEF);
    wr(3, 3, 24'h123456);
    for (int i = 1; i < 4; i++) begin
      pal[i] = {8'(i * 40 + 16), 8'(128 - i * 20), 8'(200 - i * 50)};
      wr(2, i, int'(pal[i]));
    end
    for (int c = 0; c < 44; c++) begin
      sh_seq[c] = (c % 9 == 4) ? 63 - (c % 4) : (c * 7 + 3) % 48;
      wr(1, c, sh_seq[c]);
    end
    wr(3, 0, 0);
    frame();
    // R1 R2 R3 R4: exhaustive normal-height sweep
    for (int y = 0; y < 32; y++)
      for (int x = 0; x < 352; x++) px(x, y, 0, "R2 R3 R4 normal sweep");
    // R5: lines past the slice height in normal mode
    for (int y = 32; y < 64; y++)
      for (int x = 0; x < 352; x += 11) px(x, y, 0, "R5 normal out of range");
    // R6: columns past the window
    for (int x = 352; x < 512; x++) px(x, 7, 0, "R6 x out of range");
    // R5: double height
    for (int y = 0; y < 64; y++)
      for (int x = 0; x < 352; x += 3) px(x, y, 1, "R5 double height");
    // R1: idle cycle between pixels
    @(negedge clk);
    check("R1 idle output", {out_valid, out_transp, out_color}, {1'b0, 1'b1, 24'h0});
    // R7: shadow writes do not reach display before frame_start
    for (int c = 0; c < 44; c++) begin
      sh_seq[c] = (c == 10) ? 50 : (c * 5 + 1) % 48;
      wr(1, c, sh_seq[c]);
    end
    for (int x = 0; x < 352; x += 2) px(x, 9, 0, "R7 old order before frame");
    frame();
    for (int y = 0; y < 32; y += 4)
      for (int x = 0; x < 352; x++) px(x, y, 0, "R7 new order after frame");
    for (int y = 0; y < 64; y += 7)
      for (int x = 0; x < 352; x += 5) px(x, y, 1, "R7 R5 new order double");
    finish_run();
  end
endmodule